// File: doc/BRIEF.md
# ATA device detection sequencer

This block runs on the host side of an ATA channel. It probes one device position, device 0 or device 1, and reports what is attached there. It reaches the device only through a task-file register master port. That port carries a 4-bit address, write data, a write flag, a strobe, read data and a ready.

A probe begins with a start pulse. The block clears the device control register and selects the device. It then writes an alternating scratch pattern into the sector count and sector number registers and reads it back. A wrong read-back means no device, and the block finishes at once. A correct read-back makes the type "unknown". The block then asks a companion reset sequencer for a soft reset and ignores how that reset ends. After the reset it selects the device again and reads the reset signature bytes, and from these it decides whether to count the device and which type to report.

The result is a device count, a two-bit type code and a one-cycle done pulse. The count and type hold their values until the next probe begins.

Top module: `ata_probe_seq`

## Requirements
- R1: After start, the block writes 0x00 to the device control register at address 0xE. It then writes the device/head register at address 6 with 0x10 for device 1 or 0x00 for device 0. Between the end of that device/head write and the next strobe, at least ceil(SETTLE_NS*CLK_MHZ/1000) cycles pass (20 cycles at the defaults).
- R2: Next, the block writes six scratch values, alternating between sector count (address 2) and sector number (address 3): 0x55, 0xAA, 0xAA, 0x55, 0x55, 0xAA.
- R3: The block then reads address 2 and then address 3. Unless these return 0x55 and 0xAA, it pulses done with type 0 (none) and count 0, without a reset request and without any further bus access.
- R4: On a correct read-back, the block raises srst_req and holds it until srst_ack is seen high. No strobe is issued while srst_req is high.
- R5: After the reset, the block writes device/head again with the same value and waits the settle time. It then reads address 2 and then address 3. Unless both return 0x01, it finishes with count 0 and type 1 (unknown).
- R6: When both return 0x01, the count is 1 and the block reads status (address 7), cylinder low (address 4) and cylinder high (address 5), in that order. A low/high pair of 0x14/0xEB or 0x69/0x96 gives type 3 (packet device), whatever the status byte holds.
- R7: A low/high pair of 0x00/0x00 or 0x3C/0xC3 gives type 2 (ATA) when the status byte is nonzero. Any other case gives type 1.
- R8: While reg_stb is high and reg_rdy is low, reg_addr, reg_we and reg_wdata stay stable. A transfer completes on the first clock edge where both are high. reg_stb then goes low for at least one cycle.
- R9: done is a single-cycle pulse. dev_count and dev_type change only while a probe runs, and they hold between probes. A start pulse during a probe is ignored.
- R10: While reset is held, reg_stb, srst_req, done, dev_count and dev_type are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a probe (sampled only when idle) |
| dev_sel | input | 1 | Device position to probe (0 or 1) |
| reg_stb | output | 1 | Task-file access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 4 | Register address; bit 3 selects the control block |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid with reg_rdy |
| reg_rdy | input | 1 | Access completes on this cycle |
| srst_req | output | 1 | Soft reset request to the reset sequencer |
| srst_ack | input | 1 | Soft reset finished |
| done | output | 1 | One-cycle end-of-probe pulse |
| dev_count | output | 2 | Devices counted at this position (0 or 1) |
| dev_type | output | 2 | 0 none, 1 unknown, 2 ATA, 3 packet |

## Verification
The device model is run in several setups, and each one separates a different decision:
- An absent position, whose reads float to 0xFF, and a position that holds only one of the two scratch registers. Both must stop right after the read-back.
- A present device whose post-reset count bytes are wrong. It must be reported unknown but not counted.
- Every listed signature pair. The parallel and serial packet pairs appear with both zero and nonzero status. The ATA pairs appear with nonzero status, and 0x00/0x00 also appears with zero status. An unlisted pair is included as well. Together these check that status affects only the ATA decision.

Each setup is also run with a different response latency on the register port. One run adds a second start pulse in mid-probe, with the device select flipped, which exposes any restart.

// File: rtl/ata_probe_pkg.sv
package ata_probe_pkg;

    localparam int PC_W      = 5;
    localparam int LAST_STEP = 18;

    // task-file register addresses (bit 3 selects the control block)
    localparam logic [3:0] A_SECCNT  = 4'h2;
    localparam logic [3:0] A_SECNUM  = 4'h3;
    localparam logic [3:0] A_CYLLO   = 4'h4;
    localparam logic [3:0] A_CYLHI   = 4'h5;
    localparam logic [3:0] A_DEVHEAD = 4'h6;
    localparam logic [3:0] A_STATUS  = 4'h7;
    localparam logic [3:0] A_DEVCTL  = 4'hE;

    typedef enum logic [1:0] {
        DEV_NONE    = 2'd0,
        DEV_UNKNOWN = 2'd1,
        DEV_ATA     = 2'd2,
        DEV_PACKET  = 2'd3
    } dev_kind_e;

    typedef enum logic [1:0] {OP_WR, OP_RD, OP_WAIT, OP_RST} op_kind_e;

    typedef enum logic [1:0] {EV_NONE, EV_PRESENCE, EV_SIGNATURE, EV_CLASSIFY} eval_e;

    typedef struct packed {
        op_kind_e   kind;
        logic [3:0] addr;
        logic [7:0] data;
        logic       use_sel;
        eval_e      ev;
    } uop_t;

    function automatic uop_t mk(op_kind_e k, logic [3:0] a, logic [7:0] d, logic s, eval_e e);
        uop_t u;
        u.kind = k; u.addr = a; u.data = d; u.use_sel = s; u.ev = e;
        return u;
    endfunction

    // probe program, one micro-operation per step
    function automatic uop_t uop_at(logic [PC_W-1:0] idx);
        case (idx)
            5'd0:    return mk(OP_WR,   A_DEVCTL,  8'h00, 1'b0, EV_NONE);
            5'd1:    return mk(OP_WR,   A_DEVHEAD, 8'h00, 1'b1, EV_NONE);
            5'd2:    return mk(OP_WAIT, 4'h0,      8'h00, 1'b0, EV_NONE);
            5'd3:    return mk(OP_WR,   A_SECCNT,  8'h55, 1'b0, EV_NONE);
            5'd4:    return mk(OP_WR,   A_SECNUM,  8'hAA, 1'b0, EV_NONE);
            5'd5:    return mk(OP_WR,   A_SECCNT,  8'hAA, 1'b0, EV_NONE);
            5'd6:    return mk(OP_WR,   A_SECNUM,  8'h55, 1'b0, EV_NONE);
            5'd7:    return mk(OP_WR,   A_SECCNT,  8'h55, 1'b0, EV_NONE);
            5'd8:    return mk(OP_WR,   A_SECNUM,  8'hAA, 1'b0, EV_NONE);
            5'd9:    return mk(OP_RD,   A_SECCNT,  8'h00, 1'b0, EV_NONE);
            5'd10:   return mk(OP_RD,   A_SECNUM,  8'h00, 1'b0, EV_PRESENCE);
            5'd11:   return mk(OP_RST,  4'h0,      8'h00, 1'b0, EV_NONE);
            5'd12:   return mk(OP_WR,   A_DEVHEAD, 8'h00, 1'b1, EV_NONE);
            5'd13:   return mk(OP_WAIT, 4'h0,      8'h00, 1'b0, EV_NONE);
            5'd14:   return mk(OP_RD,   A_SECCNT,  8'h00, 1'b0, EV_NONE);
            5'd15:   return mk(OP_RD,   A_SECNUM,  8'h00, 1'b0, EV_SIGNATURE);
            5'd16:   return mk(OP_RD,   A_STATUS,  8'h00, 1'b0, EV_NONE);
            5'd17:   return mk(OP_RD,   A_CYLLO,   8'h00, 1'b0, EV_NONE);
            5'd18:   return mk(OP_RD,   A_CYLHI,   8'h00, 1'b0, EV_CLASSIFY);
            default: return mk(OP_WAIT, 4'h0,      8'h00, 1'b0, EV_NONE);
        endcase
    endfunction

    function automatic dev_kind_e classify(logic [7:0] st, logic [7:0] lo, logic [7:0] hi);
        logic pkt, ata;
        pkt = (lo == 8'h14 && hi == 8'hEB) || (lo == 8'h69 && hi == 8'h96);
        ata = (lo == 8'h00 && hi == 8'h00) || (lo == 8'h3C && hi == 8'hC3);
        if (pkt)                 return DEV_PACKET;
        if (ata && st != 8'h00)  return DEV_ATA;
        return DEV_UNKNOWN;
    endfunction

endpackage

// File: rtl/ata_probe_wait.sv
module ata_probe_wait #(
    parameter int CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy,
    output logic fin
);
    localparam int CW = (CYC < 2) ? 1 : $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            fin  <= 1'b0;
            cnt  <= '0;
        end else begin
            fin <= 1'b0;
            if (busy) begin
                if (cnt == '0) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (go) begin
                busy <= 1'b1;
                cnt  <= CW'(CYC - 1);
            end
        end
    end

    // R1
    fin_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        fin |-> !busy);
endmodule

// File: rtl/ata_probe_bus.sv
module ata_probe_bus (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic       go_we,
    input  logic [3:0] go_addr,
    input  logic [7:0] go_wdata,
    output logic       fin,
    output logic [7:0] rdata_q,
    output logic       reg_stb,
    output logic       reg_we,
    output logic [3:0] reg_addr,
    output logic [7:0] reg_wdata,
    input  logic [7:0] reg_rdata,
    input  logic       reg_rdy
);
    always_ff @(posedge clk) begin
        if (rst) begin
            reg_stb   <= 1'b0;
            reg_we    <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            fin       <= 1'b0;
            rdata_q   <= '0;
        end else begin
            fin <= 1'b0;
            if (reg_stb && reg_rdy) begin
                reg_stb <= 1'b0;
                fin     <= 1'b1;
                rdata_q <= reg_rdata;
            end else if (go && !reg_stb) begin
                reg_stb   <= 1'b1;
                reg_we    <= go_we;
                reg_addr  <= go_addr;
                reg_wdata <= go_wdata;
            end
        end
    end

    // R8
    hold_while_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_stb && !reg_rdy) |=> (reg_stb && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)));

    // R8
    gap_after_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_stb && reg_rdy) |=> !reg_stb);
endmodule

// File: rtl/ata_probe_seq.sv
module ata_probe_seq
    import ata_probe_pkg::*;
#(
    parameter int CLK_MHZ   = 50,
    parameter int SETTLE_NS = 400
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       dev_sel,
    output logic       reg_stb,
    output logic       reg_we,
    output logic [3:0] reg_addr,
    output logic [7:0] reg_wdata,
    input  logic [7:0] reg_rdata,
    input  logic       reg_rdy,
    output logic       srst_req,
    input  logic       srst_ack,
    output logic       done,
    output logic [1:0] dev_count,
    output logic [1:0] dev_type
);
    localparam int SETTLE_CYC = (SETTLE_NS * CLK_MHZ + 999) / 1000;
    localparam int WAIT_CYC   = (SETTLE_CYC < 1) ? 1 : SETTLE_CYC;

    typedef enum logic [2:0] {S_IDLE, S_FETCH, S_BUS, S_DLY, S_RST, S_EVAL} st_e;

    st_e             state;
    logic [PC_W-1:0] pc;
    logic            sel_q;
    dev_kind_e       type_q;
    logic [1:0]      count_q;
    logic [7:0]      sc_q, sn_q, st_q, lo_q, hi_q;
    uop_t            cur;
    logic            bus_go, bus_fin, dly_go, dly_fin, dly_busy;
    logic [7:0]      bus_rdata, wr_val;

    always_comb begin
        cur    = uop_at(pc);
        wr_val = cur.use_sel ? {3'b000, sel_q, 4'b0000} : cur.data;
        bus_go = (state == S_FETCH) && (cur.kind == OP_WR || cur.kind == OP_RD);
        dly_go = (state == S_FETCH) && (cur.kind == OP_WAIT);
    end

    ata_probe_bus u_bus (
        .clk(clk), .rst(rst), .go(bus_go), .go_we(cur.kind == OP_WR),
        .go_addr(cur.addr), .go_wdata(wr_val), .fin(bus_fin), .rdata_q(bus_rdata),
        .reg_stb(reg_stb), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rdy(reg_rdy)
    );

    ata_probe_wait #(.CYC(WAIT_CYC)) u_wait (
        .clk(clk), .rst(rst), .go(dly_go), .busy(dly_busy), .fin(dly_fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            pc       <= '0;
            sel_q    <= 1'b0;
            type_q   <= DEV_NONE;
            count_q  <= '0;
            srst_req <= 1'b0;
            done     <= 1'b0;
            sc_q <= '0; sn_q <= '0; st_q <= '0; lo_q <= '0; hi_q <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    sel_q   <= dev_sel;
                    pc      <= '0;
                    type_q  <= DEV_NONE;
                    count_q <= '0;
                    state   <= S_FETCH;
                end
                S_FETCH: begin
                    case (cur.kind)
                        OP_WAIT: state <= S_DLY;
                        OP_RST:  begin srst_req <= 1'b1; state <= S_RST; end
                        default: state <= S_BUS;
                    endcase
                end
                S_BUS: if (bus_fin) begin
                    if (cur.kind == OP_RD) begin
                        case (cur.addr)
                            A_SECCNT: sc_q <= bus_rdata;
                            A_SECNUM: sn_q <= bus_rdata;
                            A_STATUS: st_q <= bus_rdata;
                            A_CYLLO:  lo_q <= bus_rdata;
                            A_CYLHI:  hi_q <= bus_rdata;
                            default:  ;
                        endcase
                    end
                    if (cur.ev != EV_NONE) state <= S_EVAL;
                    else begin pc <= pc + 1'b1; state <= S_FETCH; end
                end
                S_DLY: if (dly_fin) begin
                    pc    <= pc + 1'b1;
                    state <= S_FETCH;
                end
                S_RST: if (srst_ack) begin
                    srst_req <= 1'b0;
                    pc       <= pc + 1'b1;
                    state    <= S_FETCH;
                end
                S_EVAL: begin
                    case (cur.ev)
                        EV_PRESENCE: if (sc_q == 8'h55 && sn_q == 8'hAA) begin
                            type_q <= DEV_UNKNOWN;
                            pc     <= pc + 1'b1;
                            state  <= S_FETCH;
                        end else begin
                            done  <= 1'b1;
                            state <= S_IDLE;
                        end
                        EV_SIGNATURE: if (sc_q == 8'h01 && sn_q == 8'h01) begin
                            count_q <= 2'd1;
                            pc      <= pc + 1'b1;
                            state   <= S_FETCH;
                        end else begin
                            done  <= 1'b1;
                            state <= S_IDLE;
                        end
                        EV_CLASSIFY: begin
                            type_q <= classify(st_q, lo_q, hi_q);
                            done   <= 1'b1;
                            state  <= S_IDLE;
                        end
                        default: begin
                            pc    <= pc + 1'b1;
                            state <= S_FETCH;
                        end
                    endcase
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign dev_type  = type_q;
    assign dev_count = count_q;

    // R4
    rst_req_held_chk: assert property (@(posedge clk) disable iff (rst)
        (srst_req && !srst_ack) |=> srst_req);

    // R4
    no_bus_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
        srst_req |-> !reg_stb);

    // R1
    no_bus_in_settle_chk: assert property (@(posedge clk) disable iff (rst)
        dly_busy |-> !reg_stb);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && !start) |=> ($stable(dev_type) && $stable(dev_count)));

    // R3
    none_uncounted_chk: assert property (@(posedge clk) disable iff (rst)
        (done && dev_type == DEV_NONE) |-> dev_count == 2'd0);

    // R5
    counted_typed_chk: assert property (@(posedge clk) disable iff (rst)
        (done && dev_count == 2'd1) |-> dev_type != DEV_NONE);
endmodule

// File: tb/tb_ata_probe_seq.sv
module tb_ata_probe_seq;
    localparam int CLK_MHZ  = 50;
    localparam int WAIT_CYC = (400 * CLK_MHZ + 999) / 1000;

    logic       clk = 1'b0, rst = 1'b1, start = 1'b0, dev_sel = 1'b0;
    logic       reg_stb, reg_we, srst_req, done;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata = 8'h00;
    logic       reg_rdy = 1'b0, srst_ack = 1'b0;
    logic [1:0] dev_count, dev_type;

    ata_probe_seq #(.CLK_MHZ(CLK_MHZ), .SETTLE_NS(400)) dut (
        .clk(clk), .rst(rst), .start(start), .dev_sel(dev_sel),
        .reg_stb(reg_stb), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rdy(reg_rdy), .srst_req(srst_req), .srst_ack(srst_ack),
        .done(done), .dev_count(dev_count), .dev_type(dev_type)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_err = 0;

    task automatic chk(bit ok, string tag, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // device model configuration (written by the stimulus only)
    bit         m_pres, m_stuck;
    logic [7:0] m_psc, m_psn, m_cl, m_ch, m_st;
    int         run_id = 0;
    logic [12:0] exp_a [16];
    int         exp_n = 0;

    // device model state (written by the model only)
    logic [7:0] r_sc, r_sn, r_cl, r_ch, r_st;
    logic [12:0] got;
    int  seen_id = 0, lat = 0, rcnt = 3, cyc = 0, tx_idx = 0, tx_tot = 0;
    int  dh_mark = 0, min_gap = 1 << 30;
    bit  saw_rst = 0, gap_arm = 0, prev_stb = 0;

    function automatic string tag_for(int i);
        if (i < 2)  return "R1 R8 access";
        if (i < 8)  return "R2 R8 access";
        if (i < 10) return "R3 R8 access";
        if (i < 13) return "R5 R8 access";
        return "R6 R8 access";
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (run_id != seen_id) begin
            seen_id = run_id;
            r_sc = 8'h00; r_sn = 8'h00; r_cl = 8'h7E; r_ch = 8'h7E; r_st = 8'h50;
            tx_idx = 0; saw_rst = 0; gap_arm = 0; min_gap = 1 << 30;
        end
        if (reg_stb && !prev_stb && gap_arm) begin
            if (cyc - dh_mark < min_gap) min_gap = cyc - dh_mark;
            gap_arm = 0;
        end
        prev_stb = reg_stb;
        if (reg_rdy) reg_rdy = 1'b0;
        else if (reg_stb) begin
            if (lat > 0) lat--;
            else begin
                got = {reg_addr, reg_we, reg_we ? reg_wdata : 8'h00};
                chk(tx_idx < exp_n && got == exp_a[tx_idx], tag_for(tx_idx),
                    int'(got), (tx_idx < exp_n) ? int'(exp_a[tx_idx]) : -1);
                tx_idx++;
                if (reg_we) begin
                    case (reg_addr)
                        4'h2: if (m_pres) r_sc = reg_wdata;
                        4'h3: if (m_pres && !m_stuck) r_sn = reg_wdata;
                        4'h6: begin dh_mark = cyc; gap_arm = 1; end
                        default: ;
                    endcase
                end else if (!m_pres) reg_rdata = 8'hFF;
                else begin
                    case (reg_addr)
                        4'h2: reg_rdata = r_sc;
                        4'h3: reg_rdata = r_sn;
                        4'h4: reg_rdata = r_cl;
                        4'h5: reg_rdata = r_ch;
                        4'h7: reg_rdata = r_st;
                        default: reg_rdata = 8'h00;
                    endcase
                end
                reg_rdy = 1'b1;
                tx_tot++;
                lat = tx_tot % 3;
            end
        end
        if (srst_ack) srst_ack = 1'b0;
        else if (srst_req) begin
            saw_rst = 1;
            if (rcnt > 0) rcnt--;
            else begin
                srst_ack = 1'b1; rcnt = 3;
                r_sc = m_psc; r_sn = m_psn; r_cl = m_cl; r_ch = m_ch; r_st = m_st;
            end
        end
        if (reg_stb && srst_req) chk(0, "R4 strobe during reset request", 1, 0);
    end

    task automatic run(bit sel, bit pres, bit stuck, logic [7:0] psc, logic [7:0] psn,
                       logic [7:0] cl, logic [7:0] ch, logic [7:0] st, bit dbl);
        int lvl, et, ec, w;
        bit ok_rb;
        logic [7:0] dh;
        logic [1:0] ht, hc;
        ok_rb = pres && !stuck;
        if (!ok_rb) begin lvl = 0; et = 0; ec = 0; end
        else if (psc != 8'h01 || psn != 8'h01) begin lvl = 1; et = 1; ec = 0; end
        else begin
            lvl = 2; ec = 1;
            if ((cl == 8'h14 && ch == 8'hEB) || (cl == 8'h69 && ch == 8'h96)) et = 3;
            else if (((cl == 8'h00 && ch == 8'h00) || (cl == 8'h3C && ch == 8'hC3)) && st != 0) et = 2;
            else et = 1;
        end
        dh = sel ? 8'h10 : 8'h00;
        exp_a[0] = {4'hE, 1'b1, 8'h00};
        exp_a[1] = {4'h6, 1'b1, dh};
        exp_a[2] = {4'h2, 1'b1, 8'h55}; exp_a[3] = {4'h3, 1'b1, 8'hAA};
        exp_a[4] = {4'h2, 1'b1, 8'hAA}; exp_a[5] = {4'h3, 1'b1, 8'h55};
        exp_a[6] = {4'h2, 1'b1, 8'h55}; exp_a[7] = {4'h3, 1'b1, 8'hAA};
        exp_a[8] = {4'h2, 1'b0, 8'h00}; exp_a[9] = {4'h3, 1'b0, 8'h00};
        exp_a[10] = {4'h6, 1'b1, dh};
        exp_a[11] = {4'h2, 1'b0, 8'h00}; exp_a[12] = {4'h3, 1'b0, 8'h00};
        exp_a[13] = {4'h7, 1'b0, 8'h00}; exp_a[14] = {4'h4, 1'b0, 8'h00};
        exp_a[15] = {4'h5, 1'b0, 8'h00};
        exp_n = (lvl == 0) ? 10 : (lvl == 1) ? 13 : 16;
        m_pres = pres; m_stuck = stuck; m_psc = psc; m_psn = psn;
        m_cl = cl; m_ch = ch; m_st = st;
        @(negedge clk);
        run_id++;
        @(negedge clk);
        dev_sel = sel; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        w = 0;
        if (dbl) begin
            repeat (15) @(negedge clk);
            dev_sel = ~sel; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            w = 16;
        end
        while (!done && w < 3000) begin
            @(negedge clk);
            w++;
        end
        chk(w < 3000, "R9 watchdog on done", w, 0);
        chk(dev_type == 2'(et), "R6 R7 type", dev_type, et);
        chk(dev_count == 2'(ec), "R5 count", dev_count, ec);
        chk(tx_idx == exp_n, "R3 access count", tx_idx, exp_n);
        chk(saw_rst == ok_rb, "R4 reset request", saw_rst, ok_rb);
        chk(min_gap >= WAIT_CYC, "R1 settle gap", min_gap, WAIT_CYC);
        ht = dev_type; hc = dev_count;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!done && dev_type == ht && dev_count == hc, "R9 hold",
                {done, dev_type, dev_count}, {1'b0, ht, hc});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!reg_stb && !srst_req && !done && dev_count == 0 && dev_type == 0,
            "R10 reset state", {reg_stb, srst_req, done, dev_count, dev_type}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        run(1'b0, 1'b0, 1'b0, 8'h01, 8'h01, 8'h00, 8'h00, 8'h50, 1'b0); // absent
        run(1'b1, 1'b1, 1'b1, 8'h01, 8'h01, 8'h00, 8'h00, 8'h50, 1'b0); // half scratch
        run(1'b1, 1'b1, 1'b0, 8'h01, 8'h01, 8'h00, 8'h00, 8'h50, 1'b1); // ATA, restart ignored
        run(1'b0, 1'b1, 1'b0, 8'h01, 8'h01, 8'h14, 8'hEB, 8'h00, 1'b0); // packet, zero status
        run(1'b1, 1'b1, 1'b0, 8'h01, 8'h01, 8'h69, 8'h96, 8'h50, 1'b0); // packet serial
        run(1'b0, 1'b1, 1'b0, 8'h01, 8'h01, 8'h3C, 8'hC3, 8'h50, 1'b0); // ATA serial
        run(1'b0, 1'b1, 1'b0, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 1'b0); // ATA sig, zero status
        run(1'b1, 1'b1, 1'b0, 8'h01, 8'h00, 8'h00, 8'h00, 8'h50, 1'b0); // not counted
        run(1'b0, 1'b1, 1'b0, 8'h01, 8'h01, 8'h12, 8'h34, 8'h50, 1'b0); // other signature
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "R9 global watchdog", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule